// File: doc/BRIEF.md
# Line-Locking Reference Divider and Phase Comparator

This block is the digital front end of a clock synthesizer that can lock its output to a video line rate. It takes either a horizontal sync input or a free-running oscillator as the loop reference and divides it by a programmable modulus. A second programmable counter divides the synthesized output clock, which is the loop feedback. A phase-frequency detector compares the two divided streams. It raises an up request when the reference side leads and a down request when the feedback side leads. Both requests feed an external charge pump.

A hold ("coast") function lets the vertical sync level freeze the loop during blanking intervals. While the hold is active, both pump requests are forced low and any half-finished comparison is discarded. The block also decodes a charge-pump current code and a post-divider code into the values the analog section uses. All inputs are sampled in the system clock domain, which must run well above every input toggle rate. All outputs are registered.

Top module: `lf_line_lock_front`

## Requirements
- R1: The reference divide ratio is `ref_word + 2`. After reset, `up_o` rises on the Nth selected reference edge and on no earlier edge, within 4 clock cycles of the input transition.
- R2: The feedback divide ratio is `fb_word + 8`, counted on rising edges of `fbclk_in`. `dn_o` rises on the Mth edge and on no earlier edge. The full word 4095 gives 4103.
- R3: A word below the legal minimum is clamped to the minimum ratio. `ref_word` = 0 gives a ratio of 3, and `fb_word` values 0 to 3 give a ratio of 12.
- R4: `ref_sel` = 0 takes the reference from `hsync_in`, and `ref_sel` = 1 takes it from rising edges of `osc_in`. The input that is not selected has no effect on `up_o`.
- R5: `hs_falling` = 0 counts rising edges of `hsync_in`, and `hs_falling` = 1 counts falling edges.
- R6: `up_o` is set by a divided reference pulse and `dn_o` by a divided feedback pulse. Once both are high, both are high for exactly one cycle and then both are low.
- R7: With `pump_always` = 0, the loop holds while the `vsync_in` level equals `coast_high`: value 0 holds while vsync is low, value 1 holds while it is high. During the hold `up_o` and `dn_o` are low, and a request pending when the hold starts is not released when the hold ends.
- R8: With `pump_always` = 1, `vsync_in` has no effect on `up_o` or `dn_o`.
- R9: `icp_ua_o` is the charge-pump current in µA, equal to 1 shifted left by `icp_code` (1 to 128). It is registered and resets to 1.
- R10: `post_div_o` is the post-divider ratio, equal to 2 shifted left by `post_code` (2, 4, 8 or 16). It is registered and resets to 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| hsync_in | input | 1 | Horizontal sync reference candidate |
| osc_in | input | 1 | Oscillator reference candidate |
| vsync_in | input | 1 | Vertical sync level, used for hold |
| fbclk_in | input | 1 | Synthesized output clock (feedback) |
| ref_sel | input | 1 | 0 = hsync reference, 1 = oscillator reference |
| hs_falling | input | 1 | 0 = rising hsync edge, 1 = falling |
| pump_always | input | 1 | 1 = never hold, 0 = vsync-controlled hold |
| coast_high | input | 1 | Vsync level that holds the loop |
| icp_code | input | 3 | Charge-pump current code |
| post_code | input | 2 | Post-divider code |
| ref_word | input | 7 | Reference modulus word (ratio = word + 2) |
| fb_word | input | 12 | Feedback modulus word (ratio = word + 8) |
| up_o | output | 1 | Pump-up request |
| dn_o | output | 1 | Pump-down request |
| icp_ua_o | output | 8 | Decoded pump current in µA |
| post_div_o | output | 5 | Decoded post-divide ratio |

## Verification
The bench counts reference and feedback edges up to one short of the expected ratio and then exactly to it. An off-by-one divider, a wrong offset or a missing clamp therefore shows as a request that comes one edge early or late. Toggle sequences with an unequal number of rising and falling transitions expose an inverted edge polarity. Toggling the unselected source exposes a leaky reference mux. The hold tests place a complete divided reference inside the hold window and then release it. A phase detector that only masks its outputs, rather than clearing its state, releases a stale up request at that point. A monitor counts the cycles in which both requests are high; a reset path that is missing or too slow changes that count from one.

// File: rtl/lf_pkg.sv
package lf_pkg;
  typedef enum logic {
    REF_FROM_HSYNC = 1'b0,
    REF_FROM_OSC   = 1'b1
  } ref_src_e;

  localparam int REF_WORD_W_DEF = 7;
  localparam int FB_WORD_W_DEF  = 12;
  localparam int REF_OFS_DEF    = 2;
  localparam int FB_OFS_DEF     = 8;
  localparam int REF_MIN_DEF    = 3;
  localparam int FB_MIN_DEF     = 12;
endpackage

// File: rtl/lf_edge_detect.sv
module lf_edge_detect (
  input  logic clk,
  input  logic rst,
  input  logic din,
  input  logic fall_sel,
  output logic edge_o
);
  logic smp_q;
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      smp_q  <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      smp_q  <= din;
      prev_q <= smp_q;
    end
  end

  always_comb begin
    if (fall_sel) edge_o = prev_q & ~smp_q;
    else          edge_o = smp_q & ~prev_q;
  end

  // R5: an edge indication lasts a single cycle
  a_r5_edge_isolated: assert property (@(posedge clk) disable iff (rst)
    edge_o |=> !edge_o);
endmodule

// File: rtl/lf_mod_div.sv
module lf_mod_div #(
  parameter int WORD_W    = 12,
  parameter int OFFSET    = 8,
  parameter int MIN_RATIO = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              edge_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              pulse_o
);
  localparam int MAX_RATIO = (1 << WORD_W) - 1 + OFFSET;
  localparam int CNT_W     = $clog2(MAX_RATIO + 1);

  logic [CNT_W-1:0] raw_ratio;
  logic [CNT_W-1:0] ratio;
  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    raw_ratio = CNT_W'(word_i) + CNT_W'(OFFSET);
    if (raw_ratio < CNT_W'(MIN_RATIO)) ratio = CNT_W'(MIN_RATIO);
    else                               ratio = raw_ratio;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      pulse_o <= 1'b0;
    end else begin
      pulse_o <= 1'b0;
      if (edge_i) begin
        if (cnt_q >= ratio - CNT_W'(1)) begin
          cnt_q   <= '0;
          pulse_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
    end
  end

  // R1 / R2: a divided pulse only follows an input edge
  a_r1_pulse_after_edge: assert property (@(posedge clk) disable iff (rst)
    pulse_o |-> $past(edge_i));
  // R2: divided pulses never come back to back
  a_r2_pulse_single: assert property (@(posedge clk) disable iff (rst)
    pulse_o |=> !pulse_o);
endmodule

// File: rtl/lf_pfd.sv
module lf_pfd (
  input  logic clk,
  input  logic rst,
  input  logic ref_p,
  input  logic fb_p,
  input  logic coast,
  output logic up_o,
  output logic dn_o
);
  always_ff @(posedge clk) begin
    if (rst || coast) begin
      up_o <= 1'b0;
      dn_o <= 1'b0;
    end else if (up_o && dn_o) begin
      up_o <= 1'b0;
      dn_o <= 1'b0;
    end else begin
      if (ref_p) up_o <= 1'b1;
      if (fb_p)  dn_o <= 1'b1;
    end
  end

  // R7: a hold forces both requests low on the next cycle
  a_r7_coast_blocks: assert property (@(posedge clk) disable iff (rst)
    coast |=> (!up_o && !dn_o));
  // R6: coincident requests are cleared after one cycle
  a_r6_pair_clears: assert property (@(posedge clk) disable iff (rst)
    (up_o && dn_o) |=> (!up_o && !dn_o));
  // R6: up only rises after a divided reference pulse
  a_r6_up_source: assert property (@(posedge clk) disable iff (rst)
    $rose(up_o) |-> $past(ref_p));
  // R6: down only rises after a divided feedback pulse
  a_r6_dn_source: assert property (@(posedge clk) disable iff (rst)
    $rose(dn_o) |-> $past(fb_p));
endmodule

// File: rtl/lf_line_lock_front.sv
module lf_line_lock_front
  import lf_pkg::*;
#(
  parameter int REF_WORD_W = REF_WORD_W_DEF,
  parameter int FB_WORD_W  = FB_WORD_W_DEF,
  parameter int REF_OFS    = REF_OFS_DEF,
  parameter int FB_OFS     = FB_OFS_DEF,
  parameter int REF_MIN    = REF_MIN_DEF,
  parameter int FB_MIN     = FB_MIN_DEF,
  parameter int ICP_W      = 3,
  parameter int POST_W     = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   hsync_in,
  input  logic                   osc_in,
  input  logic                   vsync_in,
  input  logic                   fbclk_in,
  input  logic                   ref_sel,
  input  logic                   hs_falling,
  input  logic                   pump_always,
  input  logic                   coast_high,
  input  logic [ICP_W-1:0]       icp_code,
  input  logic [POST_W-1:0]      post_code,
  input  logic [REF_WORD_W-1:0]  ref_word,
  input  logic [FB_WORD_W-1:0]   fb_word,
  output logic                   up_o,
  output logic                   dn_o,
  output logic [(1<<ICP_W)-1:0]  icp_ua_o,
  output logic [(1<<POST_W):0]   post_div_o
);
  localparam int ICP_OUT_W  = 1 << ICP_W;
  localparam int POST_OUT_W = (1 << POST_W) + 1;

  logic hs_edge, osc_edge, fb_edge, ref_edge;
  logic ref_pulse, fb_pulse;
  logic vs_q, coast;
  ref_src_e src;

  lf_edge_detect u_hs_edge  (.clk(clk), .rst(rst), .din(hsync_in), .fall_sel(hs_falling), .edge_o(hs_edge));
  lf_edge_detect u_osc_edge (.clk(clk), .rst(rst), .din(osc_in),   .fall_sel(1'b0),       .edge_o(osc_edge));
  lf_edge_detect u_fb_edge  (.clk(clk), .rst(rst), .din(fbclk_in), .fall_sel(1'b0),       .edge_o(fb_edge));

  assign src      = ref_src_e'(ref_sel);
  assign ref_edge = (src == REF_FROM_OSC) ? osc_edge : hs_edge;

  lf_mod_div #(.WORD_W(REF_WORD_W), .OFFSET(REF_OFS), .MIN_RATIO(REF_MIN)) u_ref_div (
    .clk(clk), .rst(rst), .edge_i(ref_edge), .word_i(ref_word), .pulse_o(ref_pulse));

  lf_mod_div #(.WORD_W(FB_WORD_W), .OFFSET(FB_OFS), .MIN_RATIO(FB_MIN)) u_fb_div (
    .clk(clk), .rst(rst), .edge_i(fb_edge), .word_i(fb_word), .pulse_o(fb_pulse));

  always_ff @(posedge clk) begin
    if (rst) vs_q <= 1'b0;
    else     vs_q <= vsync_in;
  end

  assign coast = ~pump_always & (vs_q == coast_high);

  lf_pfd u_pfd (.clk(clk), .rst(rst), .ref_p(ref_pulse), .fb_p(fb_pulse),
                .coast(coast), .up_o(up_o), .dn_o(dn_o));

  always_ff @(posedge clk) begin
    if (rst) begin
      icp_ua_o   <= ICP_OUT_W'(1);
      post_div_o <= POST_OUT_W'(2);
    end else begin
      icp_ua_o   <= ICP_OUT_W'(1) << icp_code;
      post_div_o <= POST_OUT_W'(2) << post_code;
    end
  end

  // R9: the current weight is always a single binary step
  a_r9_icp_weight: assert property (@(posedge clk) disable iff (rst)
    $countones(icp_ua_o) == 1);
  // R10: the post-divide ratio is an even power of two
  a_r10_post_pow2: assert property (@(posedge clk) disable iff (rst)
    ($countones(post_div_o) == 1) && !post_div_o[0]);
  // R8: with the pump always on, a vsync change never drops a pending up
  a_r8_no_hold: assert property (@(posedge clk) disable iff (rst)
    (pump_always && $past(pump_always) && up_o && !dn_o) |=> (up_o || dn_o));
endmodule

// File: tb/test_lf_line_lock_front.sv
module test_lf_line_lock_front;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hsync_in = 1'b0, osc_in = 1'b0, vsync_in = 1'b0, fbclk_in = 1'b0;
  logic ref_sel = 1'b0, hs_falling = 1'b0, pump_always = 1'b1, coast_high = 1'b0;
  logic [2:0] icp_code = 3'd0;
  logic [1:0] post_code = 2'd0;
  logic [6:0] ref_word = 7'd2;
  logic [11:0] fb_word = 12'd4;
  logic up_o, dn_o;
  logic [7:0] icp_ua_o;
  logic [4:0] post_div_o;

  int total = 0;
  int bad = 0;
  int both_cnt = 0;

  always #2.5 clk = ~clk;

  lf_line_lock_front i_lf_line_lock_front (
    .clk(clk), .rst(rst), .hsync_in(hsync_in), .osc_in(osc_in), .vsync_in(vsync_in),
    .fbclk_in(fbclk_in), .ref_sel(ref_sel), .hs_falling(hs_falling),
    .pump_always(pump_always), .coast_high(coast_high), .icp_code(icp_code),
    .post_code(post_code), .ref_word(ref_word), .fb_word(fb_word),
    .up_o(up_o), .dn_o(dn_o), .icp_ua_o(icp_ua_o), .post_div_o(post_div_o));

  always @(negedge clk) if (up_o && dn_o) both_cnt++;

  function automatic int exp_ref(int w);
    return (w + 2 < 3) ? 3 : w + 2;
  endfunction
  function automatic int exp_fb(int w);
    return (w + 8 < 12) ? 12 : w + 8;
  endfunction

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1; cyc(3); rst = 1'b0; cyc(1); both_cnt = 0;
  endtask

  task automatic hs_toggle();
    hsync_in = ~hsync_in; cyc(2);
  endtask

  task automatic ref_edge();
    if (ref_sel) begin
      osc_in = 1'b1; cyc(2); osc_in = 1'b0; cyc(2);
    end else begin
      hs_toggle(); hs_toggle();
    end
  endtask

  task automatic fb_edge();
    fbclk_in = 1'b1; cyc(2); fbclk_in = 1'b0; cyc(2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n, m;
    void'($urandom(32'd1234));
    icp_code = 3'd5; post_code = 2'd3;
    cyc(3);
    check("R9 reset current", int'(icp_ua_o), 1);
    check("R10 reset ratio", int'(post_div_o), 2);
    check("R6 reset up", int'(up_o), 0);
    check("R6 reset dn", int'(dn_o), 0);
    rst = 1'b0; cyc(2);
    check("R9 current after reset", int'(icp_ua_o), 32);
    check("R10 ratio after reset", int'(post_div_o), 16);

    // R9 / R10 decode, all codes
    for (int c = 0; c < 8; c++) begin
      icp_code = 3'(c); post_code = 2'(c % 4); cyc(2);
      check("R9 current decode", int'(icp_ua_o), 1 << c);
      check("R10 ratio decode", int'(post_div_o), 2 << (c % 4));
    end

    // R5 polarity: 7 toggles from low = 4 rises, 3 falls, ratio 4
    ref_sel = 1'b0; ref_word = 7'd2; hs_falling = 1'b0; hsync_in = 1'b0; do_reset();
    for (int i = 0; i < 7; i++) hs_toggle();
    cyc(2);
    check("R5 rising count", int'(up_o), 1);
    hs_falling = 1'b1; hsync_in = 1'b0; do_reset();
    for (int i = 0; i < 7; i++) hs_toggle();
    cyc(2);
    check("R5 falling three edges", int'(up_o), 0);
    hs_toggle(); cyc(2);
    check("R5 falling fourth edge", int'(up_o), 1);

    // R4 source select
    hs_falling = 1'b0; hsync_in = 1'b0; ref_sel = 1'b1; do_reset();
    for (int i = 0; i < 20; i++) hs_toggle();
    cyc(2);
    check("R4 hsync ignored in osc mode", int'(up_o), 0);
    for (int i = 0; i < 4; i++) ref_edge();
    cyc(2);
    check("R4 osc reference counted", int'(up_o), 1);
    ref_sel = 1'b0; do_reset();
    for (int i = 0; i < 10; i++) begin osc_in = 1'b1; cyc(2); osc_in = 1'b0; cyc(2); end
    check("R4 osc ignored in hsync mode", int'(up_o), 0);

    // R3 clamps
    ref_word = 7'd0; do_reset();
    for (int i = 0; i < 2; i++) ref_edge();
    cyc(2);
    check("R3 ref clamp early", int'(up_o), 0);
    ref_edge(); cyc(2);
    check("R3 ref clamp to 3", int'(up_o), 1);
    fb_word = 12'd3; do_reset();
    for (int i = 0; i < 11; i++) fb_edge();
    cyc(2);
    check("R3 fb clamp early", int'(dn_o), 0);
    fb_edge(); cyc(2);
    check("R3 fb clamp to 12", int'(dn_o), 1);

    // R2 maximum word
    fb_word = 12'd4095; do_reset();
    for (int i = 0; i < 4102; i++) fb_edge();
    cyc(2);
    check("R2 max ratio early", int'(dn_o), 0);
    fb_edge(); cyc(2);
    check("R2 max ratio 4103", int'(dn_o), 1);

    // R7 hold while vsync low, stale edge discarded
    ref_sel = 1'b0; ref_word = 7'd2; fb_word = 12'd4;
    pump_always = 1'b0; coast_high = 1'b0; vsync_in = 1'b0; do_reset();
    for (int i = 0; i < 4; i++) ref_edge();
    cyc(2);
    check("R7 up held low in hold", int'(up_o), 0);
    vsync_in = 1'b1; cyc(3);
    check("R7 no stale up after hold", int'(up_o), 0);
    for (int i = 0; i < 4; i++) ref_edge();
    cyc(2);
    check("R7 up after hold ends", int'(up_o), 1);
    coast_high = 1'b1; cyc(3);
    check("R7 hold while vsync high", int'(up_o), 0);

    // R8 pump always on ignores vsync
    pump_always = 1'b1; cyc(2);
    for (int i = 0; i < 4; i++) ref_edge();
    cyc(2);
    check("R8 up with vsync at hold level", int'(up_o), 1);
    vsync_in = 1'b0; cyc(3);
    vsync_in = 1'b1; cyc(3);
    check("R8 up survives vsync toggle", int'(up_o), 1);

    // R1 / R2 / R6 random trials
    for (int t = 0; t < 8; t++) begin
      ref_sel = 1'($urandom % 2);
      hs_falling = 1'($urandom % 2);
      hsync_in = hs_falling;
      ref_word = 7'($urandom % 24);
      fb_word = 12'($urandom % 40);
      n = exp_ref(int'(ref_word));
      m = exp_fb(int'(fb_word));
      do_reset();
      for (int i = 0; i < n - 1; i++) ref_edge();
      cyc(2);
      check("R1 up before Nth edge", int'(up_o), 0);
      ref_edge(); cyc(2);
      check("R1 up at Nth edge", int'(up_o), 1);
      for (int i = 0; i < m - 1; i++) fb_edge();
      cyc(2);
      check("R2 dn before Mth edge", int'(dn_o), 0);
      check("R6 up still pending", int'(up_o), 1);
      fb_edge(); cyc(2);
      check("R6 pair cleared up", int'(up_o), 0);
      check("R6 pair cleared dn", int'(dn_o), 0);
      check("R6 overlap one cycle", both_cnt, 1);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule